// File: doc/BRIEF.md
# Capture/Reload Timer-Counter

This block is a 16-bit timer/counter with a two-byte capture/reload register, meant to sit beside a small processor core. It advances either on an internal prescaled tick or on falling edges of an external count pin. A separate trigger pin is watched for falling edges. Depending on a mode bit, such an edge either copies the running count into the capture register or reloads the count from it.

When the count rolls over from all ones, the block raises an overflow flag. A qualifying trigger edge raises an external-event flag. The two flags are ORed into a single interrupt request, and software reads the flags to tell the causes apart. When either serial baud-use indicator is high, the mode bit is overridden: the block always reloads on rollover, and the trigger pin has no effect.

Software reaches everything through a byte-wide register port. The read path is combinational. A write takes effect at the next clock edge.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, the control bits, both count bytes, both capture bytes and both flags read 0, and irq and ovf_pulse are low.
- R2: When the run bit (control bit 0, at address 0) is 0, the count holds its value.
- R3: When the source bit (control bit 1) is 0, the count advances by one on each clock in which tick_en is high. When it is 1, the count advances once per falling edge of cnt_pin. The count is read as a low byte at address 1 and a high byte at address 2.
- R4: An advance from FFFFh sets the overflow flag (control bit 6). ovf_pulse is high for exactly the one cycle after that advance.
- R5: When the trigger-enable bit (control bit 3) is 0, falling edges of trig_pin change neither the capture register nor the count, and they do not set the external flag.
- R6: With the trigger enabled and the capture bit (control bit 2) set to 1, a falling edge of trig_pin copies the count into the capture register (low byte at address 3, high byte at address 4). The count itself is left unchanged. In capture mode, a rollover wraps the count to 0.
- R7: With the capture bit at 0, every rollover loads the count from the capture register. With the trigger also enabled, a falling edge of trig_pin loads the count in the same way.
- R8: A qualifying trigger edge sets the external flag (control bit 7). irq is the OR of the two flags.
- R9: While tx_baud_use or rx_baud_use is high, the block reloads on rollover whatever the capture bit holds, and trig_pin causes no capture, no reload and no flag.
- R10: A control write with 0 in a flag bit clears that flag, and a 1 leaves it as it is. If hardware sets a flag in the same cycle as the clear, the flag ends up set.
- R11: A write to a count byte in the same cycle as an advance leaves the written value in that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Prescaled internal tick, one cycle wide |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| trig_pin | input | 1 | External trigger pin (asynchronous) |
| tx_baud_use | input | 1 | Transmit baud generation uses the overflow |
| rx_baud_use | input | 1 | Receive baud generation uses the overflow |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External-event flag |
| irq | output | 1 | Shared interrupt request |
| ovf_pulse | output | 1 | One-cycle pulse after each rollover |

## Verification
The assertions assume that the pins pass through the synchronizer before any edge is seen. They also assume that the register port, not the pins, is the only way the count and capture values change between events. For this reason, the hold, capture and reload checks excuse any cycle that carries a write to the register concerned. The stimulus drives every input on the falling clock edge. Each pin level is held for at least four cycles, so each level is sampled cleanly and every falling edge is seen exactly once. The random phase draws the tick pattern and the start counts near rollover from a fixed seed, with the trigger pin left idle, so that the bench's step model stays exact.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    SEL_CTRL   = 3'd0,
    SEL_CNT_LO = 3'd1,
    SEL_CNT_HI = 3'd2,
    SEL_CAP_LO = 3'd3,
    SEL_CAP_HI = 3'd4
  } reg_sel_e;

  // control byte bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_SRC  = 1;
  localparam int CB_CAPT = 2;
  localparam int CB_TRIG = 3;
  localparam int CB_OVF  = 6;
  localparam int CB_EXT  = 7;

  typedef struct packed {
    logic trig_en;
    logic cap_mode;
    logic ext_src;
    logic run;
  } ctrl_t;

  // mode actually in force once baud use is considered
  function automatic logic eff_capture(input logic cap_mode, input logic baud);
    return cap_mode && !baud;
  endfunction
endpackage

// File: rtl/ct_edge_sync.sv
module ct_edge_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= {STAGES{IDLE}};
      prev <= IDLE;
    end else begin
      sh   <= {sh[STAGES-2:0], pin};
      prev <= sh[STAGES-1];
    end
  end

  assign fall = prev && !sh[STAGES-1];
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int BYTE_W = 8,
  localparam int NB    = 2,
  localparam int CNT_W = NB * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              cap_mode_eff,
  input  logic              capture_ev,
  input  logic              reload_trig,
  input  logic [NB-1:0]     wr_cnt,
  input  logic [NB-1:0]     wr_cap,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  cap,
  output logic              wrap
);
  function automatic logic [CNT_W:0] bump(input logic [CNT_W-1:0] c);
    return {1'b0, c} + {{CNT_W{1'b0}}, 1'b1};
  endfunction

  logic [CNT_W:0]   sum;
  logic             reload_ev;
  logic [CNT_W-1:0] base;

  assign sum       = bump(count);
  assign wrap      = inc && sum[CNT_W];
  assign reload_ev = !cap_mode_eff && (wrap || reload_trig);

  always_comb begin
    if (reload_ev)  base = cap;
    else if (inc)   base = sum[CNT_W-1:0];
    else            base = count;
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        count[b*BYTE_W +: BYTE_W] <= '0;
        cap[b*BYTE_W +: BYTE_W]   <= '0;
      end else begin
        count[b*BYTE_W +: BYTE_W] <= wr_cnt[b] ? wdata : base[b*BYTE_W +: BYTE_W];
        if (wr_cap[b])
          cap[b*BYTE_W +: BYTE_W] <= wdata;
        else if (capture_ev)
          cap[b*BYTE_W +: BYTE_W] <= count[b*BYTE_W +: BYTE_W];
      end
    end

    // R11
    sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt[b] |=> count[b*BYTE_W +: BYTE_W] == $past(wdata));
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !reload_trig && wr_cnt == '0) |=> $stable(count));

  // R6
  cap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_ev && wr_cap == '0) |=> cap == $past(count));

  // R7
  reload_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !cap_mode_eff && wr_cnt == '0) |=> count == $past(cap));

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && cap_mode_eff && wr_cnt == '0) |=> count == '0);
endmodule

// File: rtl/ct_flags.sv
module ct_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_set,
  input  logic ext_set,
  input  logic ovf_clr,
  input  logic ext_clr,
  output logic ovf_flag,
  output logic ext_flag,
  output logic irq,
  output logic ovf_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag  <= 1'b0;
      ext_flag  <= 1'b0;
      ovf_pulse <= 1'b0;
    end else begin
      if (ovf_set)      ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
      if (ext_set)      ext_flag <= 1'b1;
      else if (ext_clr) ext_flag <= 1'b0;
      ovf_pulse <= ovf_set;
    end
  end

  assign irq = ovf_flag || ext_flag;

  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf_flag);

  // R8
  ext_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_flag) |-> $past(ext_set));

  // R4
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse && !$past(ovf_set, 2)) |=> !ovf_pulse || $past(ovf_set));
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = 2 * BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  cnt_pin,
  input  logic                  trig_pin,
  input  logic                  tx_baud_use,
  input  logic                  rx_baud_use,
  input  logic [ct_pkg::REG_AW-1:0] reg_addr,
  input  logic                  reg_wr,
  input  logic [BYTE_W-1:0]     reg_wdata,
  output logic [BYTE_W-1:0]     reg_rdata,
  output logic                  ovf_flag,
  output logic                  ext_flag,
  output logic                  irq,
  output logic                  ovf_pulse
);
  import ct_pkg::*;

  ctrl_t            ctrl;
  logic             cnt_fall, trig_fall;
  logic             baud_use, cap_eff, trig_ok;
  logic             inc, wrap, capture_ev, reload_trig;
  logic             wr_ctrl;
  logic [1:0]       wr_cnt, wr_cap;
  logic [CNT_W-1:0] count, cap;

  ct_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall(cnt_fall));

  ct_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .pin(trig_pin), .fall(trig_fall));

  assign wr_ctrl   = reg_wr && reg_addr == SEL_CTRL;
  assign wr_cnt[0] = reg_wr && reg_addr == SEL_CNT_LO;
  assign wr_cnt[1] = reg_wr && reg_addr == SEL_CNT_HI;
  assign wr_cap[0] = reg_wr && reg_addr == SEL_CAP_LO;
  assign wr_cap[1] = reg_wr && reg_addr == SEL_CAP_HI;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl.run      <= reg_wdata[CB_RUN];
      ctrl.ext_src  <= reg_wdata[CB_SRC];
      ctrl.cap_mode <= reg_wdata[CB_CAPT];
      ctrl.trig_en  <= reg_wdata[CB_TRIG];
    end
  end

  assign baud_use    = tx_baud_use || rx_baud_use;
  assign cap_eff     = eff_capture(ctrl.cap_mode, baud_use);
  assign trig_ok     = ctrl.trig_en && trig_fall && !baud_use;
  assign inc         = ctrl.run && (ctrl.ext_src ? cnt_fall : tick_en);
  assign capture_ev  = trig_ok && cap_eff;
  assign reload_trig = trig_ok && !cap_eff;

  ct_counter #(.BYTE_W(BYTE_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .inc(inc), .cap_mode_eff(cap_eff),
    .capture_ev(capture_ev), .reload_trig(reload_trig),
    .wr_cnt(wr_cnt), .wr_cap(wr_cap), .wdata(reg_wdata),
    .count(count), .cap(cap), .wrap(wrap));

  ct_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ovf_set(wrap), .ext_set(trig_ok),
    .ovf_clr(wr_ctrl && !reg_wdata[CB_OVF]),
    .ext_clr(wr_ctrl && !reg_wdata[CB_EXT]),
    .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq), .ovf_pulse(ovf_pulse));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      SEL_CTRL: begin
        reg_rdata[CB_RUN]  = ctrl.run;
        reg_rdata[CB_SRC]  = ctrl.ext_src;
        reg_rdata[CB_CAPT] = ctrl.cap_mode;
        reg_rdata[CB_TRIG] = ctrl.trig_en;
        reg_rdata[CB_OVF]  = ovf_flag;
        reg_rdata[CB_EXT]  = ext_flag;
      end
      SEL_CNT_LO: reg_rdata = count[BYTE_W-1:0];
      SEL_CNT_HI: reg_rdata = count[CNT_W-1:BYTE_W];
      SEL_CAP_LO: reg_rdata = cap[BYTE_W-1:0];
      SEL_CAP_HI: reg_rdata = cap[CNT_W-1:BYTE_W];
      default:    reg_rdata = '0;
    endcase
  end

  // R9
  baud_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_use && wr_cap == '0) |=> $stable(cap));

  // R5
  trig_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.trig_en && wr_cap == '0) |=> $stable(cap));

  // R3
  src_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && !ctrl.ext_src && !tick_en && !reload_trig && wr_cnt == '0) |=> $stable(count));
endmodule

// File: tb/test_cap_reload_timer.sv
module test_cap_reload_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, cnt_pin = 1'b1, trig_pin = 1'b1;
  logic       tx_baud_use = 1'b0, rx_baud_use = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       ovf_flag, ext_flag, irq, ovf_pulse;
  int         vec = 0, bad = 0;

  always #10 clk = ~clk;

  cap_reload_timer i_cap_reload_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .tx_baud_use(tx_baud_use), .rx_baud_use(rx_baud_use),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
    .irq(irq), .ovf_pulse(ovf_pulse));

  task automatic chk(input string req, input string what, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 3'd1, hi); d = {hi, lo};
  endtask

  task automatic set16(input logic [2:0] a, input logic [15:0] v);
    wr(a, v[7:0]); wr(a + 3'd1, v[15:8]);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic trig_fall();
    @(negedge clk); trig_pin = 1'b0; repeat (5) @(negedge clk);
    trig_pin = 1'b1; repeat (5) @(negedge clk);
  endtask

  task automatic cnt_fall();
    @(negedge clk); cnt_pin = 1'b0; repeat (4) @(negedge clk);
    cnt_pin = 1'b1; repeat (4) @(negedge clk);
  endtask

  // bench model: n advances from start; rollover reloads or wraps to 0
  function automatic logic [16:0] step_model(input logic [15:0] start, input int n,
                                             input logic [15:0] rl, input logic reload);
    logic [15:0] c = start;
    logic        o = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (c == 16'hFFFF) begin c = reload ? rl : 16'h0000; o = 1'b1; end
      else c = c + 16'd1;
    end
    return {o, c};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    logic [16:0] m;
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], b); chk("R1", "reset reg", b, 0);
    end
    chk("R1", "irq", irq, 0);
    chk("R1", "ovf_pulse", ovf_pulse, 0);

    // R2 run=0 holds
    set16(3'd1, 16'h1234);
    ticks(10);
    rd16(3'd1, w); chk("R2", "held count", w, 16'h1234);

    // R3/R4/R7 random tick patterns near rollover
    for (int it = 0; it < 24; it++) begin
      logic [15:0] st, rl;
      logic        rmode;
      int          n, hi;
      st = 16'hFFFF - 16'($urandom % 40);
      rl = 16'($urandom);
      rmode = 1'($urandom % 2);
      n = 1 + ($urandom % 60);
      wr(3'd0, 8'h00);
      set16(3'd1, st); set16(3'd3, rl);
      wr(3'd0, rmode ? 8'h01 : 8'h05);
      hi = 0;
      for (int k = 0; k < n; k++) begin
        @(negedge clk); tick_en = 1'($urandom % 2); hi += int'(tick_en);
      end
      @(negedge clk); tick_en = 1'b0;
      m = step_model(st, hi, rl, rmode);
      rd16(3'd1, w); chk("R3", "random count", w, m[15:0]);
      chk("R4", "random ovf flag", ovf_flag, m[16]);
      chk("R8", "irq follows ovf", irq, m[16]);
    end
    wr(3'd0, 8'h00);

    // R4 pulse width
    set16(3'd1, 16'hFFFF); set16(3'd3, 16'h0000);
    wr(3'd0, 8'h05);
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    chk("R4", "pulse high", ovf_pulse, 1);
    @(negedge clk); chk("R4", "pulse low", ovf_pulse, 0);
    chk("R4", "flag set", ovf_flag, 1);

    // R10 clear, then set wins over clear
    wr(3'd0, 8'h05); chk("R10", "cleared", ovf_flag, 0);
    wr(3'd0, 8'h45); chk("R10", "write 1 keeps 0", ovf_flag, 0);
    set16(3'd1, 16'hFFFF);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h05; tick_en = 1'b1;
    @(negedge clk); reg_wr = 1'b0; tick_en = 1'b0;
    chk("R10", "set wins", ovf_flag, 1);
    wr(3'd0, 8'h00);

    // R11 write beats increment
    set16(3'd1, 16'h0010);
    wr(3'd0, 8'h01);
    @(negedge clk); tick_en = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h55;
    @(negedge clk); reg_wr = 1'b0; tick_en = 1'b0;
    rd16(3'd1, w); chk("R11", "write wins", w, 16'h0055);
    wr(3'd0, 8'h00);

    // R3 external count pin
    set16(3'd1, 16'h0100);
    wr(3'd0, 8'h03);
    for (int k = 0; k < 5; k++) cnt_fall();
    ticks(6);
    rd16(3'd1, w); chk("R3", "pin count", w, 16'h0105);
    wr(3'd0, 8'h00);

    // R5 trigger disabled
    set16(3'd3, 16'h2222); set16(3'd1, 16'h3333);
    wr(3'd0, 8'h04);
    trig_fall();
    rd16(3'd3, w); chk("R5", "cap unchanged", w, 16'h2222);
    rd16(3'd1, w); chk("R5", "count unchanged", w, 16'h3333);
    chk("R5", "no ext flag", ext_flag, 0);

    // R6/R8 capture
    wr(3'd0, 8'h0C);
    trig_fall();
    rd16(3'd3, w); chk("R6", "captured", w, 16'h3333);
    rd16(3'd1, w); chk("R6", "count kept", w, 16'h3333);
    chk("R8", "ext flag", ext_flag, 1);
    chk("R8", "irq", irq, 1);
    wr(3'd0, 8'h00); chk("R10", "ext cleared", ext_flag, 0);

    // R7 trigger reload
    set16(3'd3, 16'hABCD); set16(3'd1, 16'h0005);
    wr(3'd0, 8'h08);
    trig_fall();
    rd16(3'd1, w); chk("R7", "trig reload", w, 16'hABCD);
    wr(3'd0, 8'h00);

    // R9 baud use forces reload and blocks trigger
    tx_baud_use = 1'b1;
    set16(3'd3, 16'h1000); set16(3'd1, 16'hFFFE);
    wr(3'd0, 8'h0D);
    ticks(2);
    rd16(3'd1, w); chk("R9", "forced reload", w, 16'h1000);
    wr(3'd0, 8'h0C);
    tx_baud_use = 1'b0; rx_baud_use = 1'b1;
    trig_fall();
    rd16(3'd1, w); chk("R9", "count untouched", w, 16'h1000);
    rd16(3'd3, w); chk("R9", "cap untouched", w, 16'h1000);
    chk("R9", "no ext flag", ext_flag, 0);
    rx_baud_use = 1'b0;

    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule